// File: doc/BRIEF.md
# Serial EEPROM Emulation Slave

This block stands in for a small three-wire serial EEPROM of 64 words of 16 bits. Software does not drive real pins. It writes a control word in which one bit is the serial clock, one is the chip select and one is the serial data into the device. Each write of that word is treated as a new level on those lines. The block compares the new clock bit with the one it latched on the previous write. From that it sees rising and falling clock edges, shifts in a command of opcode and address, and then presents stored data, most significant bit first, on a data-out bit that is visible when the control word is read back.

When a read command has been accepted, the output bit pointer moves on by one at every falling clock edge. It runs from one word into the next and wraps from word 63 to word 0, so software can read any number of words in a single continuous pass. The storage is filled through a separate initialisation write port before use. By convention word 63 holds a checksum, chosen so that the sixteen-bit sum of all 64 words equals 0xBABA.

A sequencer with four states controls the block. `S_IDLE` means no command bits have been taken. `S_COLLECT` means command bits are arriving. `S_READ` means a read is being served. `S_IGNORE` means a command other than read was received. The transitions are as follows:
- SELECT_BIT: `S_IDLE` to `S_COLLECT` on the first rising edge with chip select high.
- DECODE_READ: `S_COLLECT` to `S_READ` on the ninth bit when the opcode is 110.
- DECODE_OTHER: `S_COLLECT` to `S_IGNORE` on the ninth bit with any other opcode.
- DESELECT: any state to `S_IDLE` on a rising edge with chip select low.

All other events leave the state where it is.

Top module: `ee_serial_slave`

## Requirements
- R1: After reset the control readback is 0x0188: present (bit 8), grant (bit 7) and data-out (bit 3) are set and every other bit is 0.
- R2: A control write that leaves the clock bit (bit 0) unchanged only latches chip select (bit 1), data-in (bit 2) and request (bit 6). The sequencer state, the bit counter and the output pointer all keep their values.
- R3: Each falling clock edge advances the output bit pointer by exactly one.
- R4: A rising clock edge with chip select low clears the shift register, the bit counter and the pointer, and returns the sequencer to `S_IDLE`. Data-out then reads 1.
- R5: A rising clock edge with chip select high shifts data-in into the least significant end of the command register and increments the bit counter.
- R6: On the ninth command bit the upper three bits (sent first) are decoded. The value 110 starts a read, and the lower six bits set the pointer to address×16−1. Any other opcode enters `S_IGNORE` and data-out stays 1.
- R7: In `S_READ`, data-out is bit 15−(p mod 16) of word ((p div 16) mod 64), where p is the pointer. After the ninth falling edge the first bit seen is the MSB of the addressed word, and reading continues across word boundaries and from word 63 to word 0.
- R8: The control readback always shows present (bit 8) and grant (bit 7), the latched clock, chip select, data-in and request bits in their own positions, and data-out in bit 3. Every other bit reads 0, and written values in those positions have no effect.
- R9: A write on the initialisation port replaces the addressed word. With the checksum convention loaded, the 64 words read serially sum to 0xBABA modulo 2^16.
- R10: Once the sequencer is in `S_READ` or `S_IGNORE`, further command bits never restart decoding. Only a deselect does that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write value |
| ctl_rdata | output | 16 | Control word readback |
| init_we | input | 1 | Storage initialisation write enable |
| init_addr | input | 6 | Storage initialisation word address |
| init_data | input | 16 | Storage initialisation word value |

## Verification
The assertions assume that a single write carries at most one clock transition. They also assume that chip select and data-in are sampled together with the clock bit of the same write, so a rising edge uses the new chip select and not the latched one. The bench keeps to these assumptions. Each write lasts exactly one cycle, with idle cycles between writes, and a bit is sent as two writes that keep chip select and data-in fixed while only the clock bit toggles. The storage is fully loaded before the first serial command, so no assertion or check ever sees data that was never written.

// File: rtl/ee_pkg.sv
package ee_pkg;
    localparam int B_SK   = 0;
    localparam int B_CS   = 1;
    localparam int B_DI   = 2;
    localparam int B_DO   = 3;
    localparam int B_REQ  = 6;
    localparam int B_GNT  = 7;
    localparam int B_PRES = 8;

    localparam int         OP_W    = 3;
    localparam logic [2:0] OP_READ = 3'b110;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_COLLECT = 2'd1,
        S_READ    = 2'd2,
        S_IGNORE  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic req;
        logic di;
        logic cs;
        logic sk;
    } ctl_bits_t;
endpackage

// File: rtl/ee_ctl_latch.sv
module ee_ctl_latch
    import ee_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  ctl_bits_t wr_bits,
    output ctl_bits_t cur,
    output logic      rise_ev,
    output logic      fall_ev
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (wr_en) begin
            cur <= wr_bits;
        end
    end

    always_comb begin
        rise_ev = wr_en &  wr_bits.sk & ~cur.sk;
        fall_ev = wr_en & ~wr_bits.sk &  cur.sk;
    end

    a_r2_latch_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cur == $past(wr_bits)));

    a_r2_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cur));
endmodule

// File: rtl/ee_seq_fsm.sv
module ee_seq_fsm
    import ee_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  rise_ev,
    input  logic                                  fall_ev,
    input  logic                                  cs_in,
    input  logic                                  di_in,
    output seq_state_e                            state,
    output logic [ADDR_W+$clog2(WORD_W)-1:0]      ptr
);
    localparam int BIT_W    = $clog2(WORD_W);
    localparam int PTR_W    = ADDR_W + BIT_W;
    localparam int CMD_BITS = OP_W + ADDR_W;
    localparam int CNT_W    = $clog2(CMD_BITS) + 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    seq_state_e          nxt;
    logic [CMD_BITS-1:0] shreg;
    logic [CMD_BITS-1:0] shift_nxt;
    logic [CNT_W-1:0]    cnt;
    logic                deselect;
    logic                shift_en;
    logic                last_bit;
    logic                op_is_read;
    logic                load_ptr;
    logic [PTR_W-1:0]    ptr_start;

    always_comb begin
        shift_nxt  = {shreg[CMD_BITS-2:0], di_in};
        deselect   = rise_ev & ~cs_in;
        shift_en   = rise_ev &  cs_in;
        last_bit   = (cnt == CNT_LAST);
        op_is_read = (shift_nxt[CMD_BITS-1 -: OP_W] == OP_READ);
        ptr_start  = {shift_nxt[ADDR_W-1:0], {BIT_W{1'b0}}} - PTR_W'(1);
    end

    // next-state and decode outputs
    always_comb begin
        nxt      = state;
        load_ptr = 1'b0;
        unique case (state)
            S_IDLE, S_COLLECT: begin
                if (shift_en) begin
                    if (last_bit) begin
                        nxt      = op_is_read ? S_READ : S_IGNORE;
                        load_ptr = op_is_read;
                    end else begin
                        nxt = S_COLLECT;
                    end
                end
            end
            S_READ:   nxt = S_READ;
            S_IGNORE: nxt = S_IGNORE;
        endcase
        if (deselect) begin
            nxt      = S_IDLE;
            load_ptr = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // command register, bit counter, output pointer
    always_ff @(posedge clk) begin
        if (!rst_n || deselect) begin
            shreg <= '0;
            cnt   <= '0;
            ptr   <= '0;
        end else if (shift_en) begin
            shreg <= shift_nxt;
            if (cnt != CNT_MAX) begin
                cnt <= cnt + CNT_W'(1);
            end
            if (load_ptr) begin
                ptr <= ptr_start;
            end
        end else if (fall_ev) begin
            ptr <= ptr + PTR_W'(1);
        end
    end

    a_r2_no_edge_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_ev && !fall_ev) |=> ($stable(state) && $stable(ptr) && $stable(cnt)));

    a_r3_fall_steps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        fall_ev |=> (ptr == PTR_W'($past(ptr) + PTR_W'(1))));

    a_r4_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_ev && !cs_in) |=> (state == S_IDLE && cnt == '0 && shreg == '0 && ptr == '0));

    a_r5_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_ev && cs_in && cnt != CNT_MAX) |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

    a_r6_decides_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_ev && cs_in && state == S_COLLECT && cnt == CNT_LAST)
            |=> (state == S_READ || state == S_IGNORE));

    a_r10_read_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READ && !(rise_ev && !cs_in)) |=> (state == S_READ));

    a_r10_ignore_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IGNORE && !(rise_ev && !cs_in)) |=> (state == S_IGNORE));
endmodule

// File: rtl/ee_word_store.sv
module ee_word_store #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic                                  clk,
    input  logic                                  we,
    input  logic [ADDR_W-1:0]                     waddr,
    input  logic [WORD_W-1:0]                     wdata,
    input  logic [ADDR_W+$clog2(WORD_W)-1:0]      rd_ptr,
    output logic                                  rd_bit
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int BIT_W = $clog2(WORD_W);
    localparam int PTR_W = ADDR_W + BIT_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] word_sel;
    logic [BIT_W-1:0]  bit_sel;
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        word_sel = rd_ptr[PTR_W-1:BIT_W];
        bit_sel  = BIT_W'(WORD_W - 1) - rd_ptr[BIT_W-1:0];
        word_q   = mem[word_sel];
        rd_bit   = word_q[bit_sel];
    end
endmodule

// File: rtl/ee_serial_slave.sv
module ee_serial_slave
    import ee_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16,
    parameter int CTL_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic              init_we,
    input  logic [ADDR_W-1:0] init_addr,
    input  logic [WORD_W-1:0] init_data
);
    localparam int PTR_W = ADDR_W + $clog2(WORD_W);

    ctl_bits_t        wr_bits;
    ctl_bits_t        cur;
    logic             rise_ev;
    logic             fall_ev;
    seq_state_e       state;
    logic [PTR_W-1:0] ptr;
    logic             rd_bit;
    logic             do_bit;
    logic             unused_wbits;

    always_comb begin
        wr_bits.sk  = ctl_wdata[B_SK];
        wr_bits.cs  = ctl_wdata[B_CS];
        wr_bits.di  = ctl_wdata[B_DI];
        wr_bits.req = ctl_wdata[B_REQ];
    end
    assign unused_wbits = ^ctl_wdata;

    ee_ctl_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr),
        .wr_bits (wr_bits),
        .cur     (cur),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    ee_seq_fsm #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev),
        .cs_in   (wr_bits.cs),
        .di_in   (wr_bits.di),
        .state   (state),
        .ptr     (ptr)
    );

    ee_word_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
        .clk    (clk),
        .we     (init_we),
        .waddr  (init_addr),
        .wdata  (init_data),
        .rd_ptr (ptr),
        .rd_bit (rd_bit)
    );

    always_comb begin
        do_bit            = (state == S_READ) ? rd_bit : 1'b1;
        ctl_rdata         = '0;
        ctl_rdata[B_SK]   = cur.sk;
        ctl_rdata[B_CS]   = cur.cs;
        ctl_rdata[B_DI]   = cur.di;
        ctl_rdata[B_DO]   = do_bit;
        ctl_rdata[B_REQ]  = cur.req;
        ctl_rdata[B_GNT]  = 1'b1;
        ctl_rdata[B_PRES] = 1'b1;
    end

    a_r4_idle_do_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[B_SK] && !ctl_rdata[B_SK] && !ctl_wdata[B_CS]) |=> ctl_rdata[B_DO]);

    a_r6_ignore_do_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IGNORE) |-> ctl_rdata[B_DO]);
endmodule

// File: tb/ee_serial_slave_tb.sv
module ee_serial_slave_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_rdata;
    logic        init_we = 1'b0;
    logic [5:0]  init_addr = '0;
    logic [15:0] init_data = '0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [15:0] model [64];

    always #5 clk = ~clk;

    ee_serial_slave u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .init_we(init_we), .init_addr(init_addr),
        .init_data(init_data)
    );

    function automatic logic [15:0] ctlw(input logic cs, input logic di, input logic sk);
        return {13'b0, di, cs, sk};
    endfunction

    function automatic logic exp_bit(input int p);
        int pm;
        pm = p & 1023;
        return model[pm >> 4][15 - (pm & 15)];
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic send_bit(input logic di);
        wr(ctlw(1'b1, di, 1'b1));
        wr(ctlw(1'b1, di, 1'b0));
    endtask

    task automatic start_cmd(input logic [2:0] op, input logic [5:0] addr);
        logic [8:0] c;
        c = {op, addr};
        wr(ctlw(1'b0, 1'b0, 1'b1));
        wr(ctlw(1'b0, 1'b0, 1'b0));
        wr(ctlw(1'b1, 1'b0, 1'b0));
        for (int i = 8; i >= 0; i--) send_bit(c[i]);
    endtask

    task automatic load(input int a, input logic [15:0] d);
        @(negedge clk);
        init_we = 1'b1;
        init_addr = 6'(a);
        init_data = d;
        @(negedge clk);
        init_we = 1'b0;
        model[a] = d;
    endtask

    initial begin
        logic [15:0] sum;
        logic [15:0] got;
        int p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset readback
        chk(ctl_rdata, 16'h0188, "R1 reset readback");

        // R9: load words; word 63 balances the sum to 0xBABA
        sum = '0;
        for (int i = 0; i < 63; i++) begin
            load(i, 16'((i * 40503) ^ 16'h5A3C));
            sum = sum + model[i];
        end
        load(63, 16'hBABA - sum);

        // R8: unrelated bits ignored, latched bits echoed (sk stays 0)
        wr(16'hFE30);
        chk(ctl_rdata, 16'h0188, "R8 unused bits read zero");
        wr(16'h0046);
        chk(ctl_rdata, 16'h01CE, "R8 R2 latched cs di req");

        // R3 R5 R6 R7: every start address, two words each, wrap at 63
        sum = '0;
        for (int a = 0; a < 64; a++) begin
            start_cmd(3'b110, 6'(a));
            p = a * 16;
            got = '0;
            for (int k = 0; k < 32; k++) begin
                chk({15'b0, ctl_rdata[3]}, {15'b0, exp_bit(p + k)}, "R3 R7 serial bit");
                if (k < 16) got = {got[14:0], ctl_rdata[3]};
                if (k < 31) send_bit(1'b0);
            end
            chk(got, model[a], "R5 R6 addressed word");
            sum = sum + got;
        end
        chk(sum, 16'hBABA, "R9 checksum over serial reads");

        // R6 R10: other opcodes leave data-out high, later bits never decode
        for (int op = 0; op < 8; op++) begin
            if (op == 6) continue;
            start_cmd(3'(op), 6'd5);
            for (int k = 0; k < 3; k++) begin
                chk({15'b0, ctl_rdata[3]}, 16'h0001, "R6 non-read opcode");
                send_bit(1'b1);
            end
            for (int i = 8; i >= 0; i--) send_bit(i == 8 || i == 7);
            chk({15'b0, ctl_rdata[3]}, 16'h0001, "R10 ignore state sticky");
        end

        // R10: a read in progress keeps streaming despite read-like bits
        start_cmd(3'b110, 6'd10);
        p = 160;
        for (int k = 0; k < 12; k++) begin
            chk({15'b0, ctl_rdata[3]}, {15'b0, exp_bit(p + k)}, "R10 read sticky");
            send_bit(k < 2);
        end

        // R2: write without clock change keeps pointer and data-out
        start_cmd(3'b110, 6'd33);
        p = 33 * 16;
        send_bit(1'b0);
        send_bit(1'b0);
        got = {15'b0, ctl_rdata[3]};
        wr(16'h0046);
        chk({15'b0, ctl_rdata[3]}, got, "R2 no-edge write keeps data-out");
        chk(ctl_rdata & 16'hFFF7, 16'h01C6, "R2 no-edge write latches bits");
        wr(16'h0002);
        send_bit(1'b0);
        chk({15'b0, ctl_rdata[3]}, {15'b0, exp_bit(p + 3)}, "R2 pointer not disturbed");

        // R4: deselect on rising edge returns to idle
        wr(ctlw(1'b0, 1'b0, 1'b1));
        chk(ctl_rdata, 16'h0189, "R4 deselect readback");
        wr(ctlw(1'b0, 1'b0, 1'b0));
        wr(ctlw(1'b1, 1'b0, 1'b0));
        send_bit(1'b1);
        chk({15'b0, ctl_rdata[3]}, 16'h0001, "R4 counter cleared, no read yet");

        // R9: initialisation port replaces a word
        load(20, 16'h1234);
        start_cmd(3'b110, 6'd20);
        got = '0;
        for (int k = 0; k < 16; k++) begin
            got = {got[14:0], ctl_rdata[3]};
            if (k < 15) send_bit(1'b0);
        end
        chk(got, 16'h1234, "R9 reloaded word");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule